// File: doc/BRIEF.md
# Probe Trigger Condition Evaluator

This block sits beside a set of probe buses that are sampled on one free-running clock. Each cycle it decides whether a trigger condition holds and, separately, whether the current sample is worth storing. Every probe owns two programmable comparators. One belongs to the trigger set and one to the capture-qualify set. A comparator either tests the probe value against a constant (equal, not equal, unsigned greater, unsigned less) or tests one selected bit of the probe for a change since the previous sample (rising, falling or either).

Within each set, the per-probe results are reduced to a single bit. The reduction is either an AND over all enabled comparators or an OR over them, and a disabled comparator is a don't-care. Both reduced bits are registered, so each sample produces its flags one clock later. Comparators and combine modes are programmed through a single-cycle register write port.

The previous-sample history is tracked by a two-state machine. `ST_WARM` means the history is not yet valid. `ST_LIVE` means edge tests may match. Reset enters `ST_WARM`. On a cycle with no configuration write, `ST_WARM` moves to `ST_LIVE`. `ST_LIVE` holds while there are no writes. A write in either state enters `ST_WARM`, so a newly programmed edge test never fires on stale history.

Top module: `trg_cond_eval`

## Requirements
- R1: After reset, trig_o and qual_o are 0, every comparator is disabled (op code 0) and both combine modes are AND.
- R2: Op code 1 matches when the probe equals the programmed value and op code 2 when it differs; a level test on a 1-bit quantity is code 1 with value 1 or 0.
- R3: Op code 3 matches when the probe is greater than the value and op code 4 when it is less, both unsigned (for example 0x80 > 2).
- R4: Op code 5 matches on a 0-to-1 change of the probe bit indexed by value[2:0] between two consecutive samples.
- R5: Op code 6 matches on a 1-to-0 change of the indexed bit between two consecutive samples.
- R6: Op code 7 matches on either change of the indexed bit; a steady bit never matches, whatever the other bits do.
- R7: On the first sample after reset, and on the first sample after any configuration write, no edge test (codes 5 to 7) matches.
- R8: In AND mode (mode bit 1), a set's output is 1 only when every enabled comparator of that set matches in the same sample; disabled probes are ignored.
- R9: In OR mode (mode bit 0), a set's output is 1 when at least one enabled comparator of that set matches.
- R10: A set with no enabled comparator drives 0 in both modes.
- R11: The capture set has its own comparators and its own mode bit, and drives qual_o independently of trig_o; both may be 1 for the same sample.
- R12: The flags for the sample taken at clock edge k appear just after edge k and hold until edge k+1. A configuration write at edge k is used first for the sample at edge k+1.
- R13: Write layout: address p (0..3) is trigger comparator p, address 4+p is capture comparator p, and address 8 is the mode word. In a comparator word, bits [10:8] hold the op code and bits [7:0] the value. In the mode word, bit 0 is the trigger mode and bit 1 the capture mode. Writes to addresses 9 to 15 change no setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| probe_i | input | 32 | Four 8-bit probe buses, probe p at bits [8p+7:8p] |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration write address |
| cfg_wdata | input | 11 | Configuration write data |
| trig_o | output | 1 | Registered trigger flag |
| qual_o | output | 1 | Registered capture-qualify flag |

## Verification
A trigger match and a capture-qualify match can fall on the same sample. The bench provokes this by programming the capture set to "probe 0 equals 1 AND probe 1 equals 0" and the trigger set to a rising edge on bit 0 of probe 2, then presenting a sample that satisfies both at once. It judges both flags in the cycle right after that edge. The neighbouring samples are also checked, to show that each flag still follows only its own set when the other is true or false.

// File: rtl/trg_pkg.sv
`timescale 1ns/1ps
package trg_pkg;

    typedef enum logic [2:0] {
        OP_OFF  = 3'd0,
        OP_EQ   = 3'd1,
        OP_NE   = 3'd2,
        OP_GT   = 3'd3,
        OP_LT   = 3'd4,
        OP_RISE = 3'd5,
        OP_FALL = 3'd6,
        OP_ANY  = 3'd7
    } trg_op_e;

    typedef enum logic {
        ST_WARM = 1'b0,
        ST_LIVE = 1'b1
    } hist_state_e;

endpackage

// File: rtl/trg_cfg_regs.sv
`timescale 1ns/1ps
module trg_cfg_regs #(
    parameter int NPROBE = 4,
    parameter int PW     = 8,
    parameter int AW     = 4,
    parameter int DW     = PW + 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we_i,
    input  logic [AW-1:0]              addr_i,
    input  logic [DW-1:0]              wdata_i,
    output logic [NPROBE-1:0][2:0]     t_op_o,
    output logic [NPROBE-1:0][PW-1:0]  t_val_o,
    output logic [NPROBE-1:0][2:0]     c_op_o,
    output logic [NPROBE-1:0][PW-1:0]  c_val_o,
    output logic                       t_and_o,
    output logic                       c_and_o
);
    localparam logic [AW-1:0] MODE_ADDR = AW'(2 * NPROBE);

    logic [2:0]    wr_op;
    logic [PW-1:0] wr_val;

    assign wr_op  = wdata_i[DW-1 -: 3];
    assign wr_val = wdata_i[PW-1:0];

    for (genvar p = 0; p < NPROBE; p++) begin : g_slot
        localparam logic [AW-1:0] T_ADDR = AW'(p);
        localparam logic [AW-1:0] C_ADDR = AW'(NPROBE + p);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                t_op_o[p]  <= 3'd0;
                t_val_o[p] <= '0;
            end else if (we_i && addr_i == T_ADDR) begin
                t_op_o[p]  <= wr_op;
                t_val_o[p] <= wr_val;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                c_op_o[p]  <= 3'd0;
                c_val_o[p] <= '0;
            end else if (we_i && addr_i == C_ADDR) begin
                c_op_o[p]  <= wr_op;
                c_val_o[p] <= wr_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_and_o <= 1'b1;
            c_and_o <= 1'b1;
        end else if (we_i && addr_i == MODE_ADDR) begin
            t_and_o <= wdata_i[0];
            c_and_o <= wdata_i[1];
        end
    end

endmodule

// File: rtl/trg_probe_cmp.sv
`timescale 1ns/1ps
module trg_probe_cmp
    import trg_pkg::*;
#(
    parameter int PW   = 8,
    parameter int SELW = (PW > 1) ? $clog2(PW) : 1
) (
    input  trg_op_e         op_i,
    input  logic [PW-1:0]   val_i,
    input  logic [PW-1:0]   cur_i,
    input  logic [PW-1:0]   prev_i,
    input  logic            hist_ok_i,
    output logic            hit_o,
    output logic            en_o
);
    logic [SELW-1:0] sel;
    logic            cur_bit;
    logic            prev_bit;

    assign sel      = val_i[SELW-1:0];
    assign cur_bit  = cur_i[sel];
    assign prev_bit = prev_i[sel];
    assign en_o     = (op_i != OP_OFF);

    always_comb begin
        unique case (op_i)
            OP_OFF:  hit_o = 1'b0;
            OP_EQ:   hit_o = (cur_i == val_i);
            OP_NE:   hit_o = (cur_i != val_i);
            OP_GT:   hit_o = (cur_i >  val_i);
            OP_LT:   hit_o = (cur_i <  val_i);
            OP_RISE: hit_o = hist_ok_i && !prev_bit &&  cur_bit;
            OP_FALL: hit_o = hist_ok_i &&  prev_bit && !cur_bit;
            OP_ANY:  hit_o = hist_ok_i && (prev_bit != cur_bit);
            default: hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/trg_combine.sv
`timescale 1ns/1ps
module trg_combine #(
    parameter int NPROBE = 4
) (
    input  logic [NPROBE-1:0] hit_i,
    input  logic [NPROBE-1:0] en_i,
    input  logic              and_mode_i,
    output logic              match_o
);
    logic any_en;
    logic all_ok;
    logic any_ok;

    assign any_en = |en_i;
    assign all_ok = &(hit_i | ~en_i);
    assign any_ok = |(hit_i & en_i);

    always_comb begin
        if (!any_en) begin
            match_o = 1'b0;
        end else if (and_mode_i) begin
            match_o = all_ok;
        end else begin
            match_o = any_ok;
        end
    end

endmodule

// File: rtl/trg_cond_eval.sv
`timescale 1ns/1ps
module trg_cond_eval
    import trg_pkg::*;
#(
    parameter  int NPROBE = 4,
    parameter  int PW     = 8,
    localparam int AW     = $clog2(2 * NPROBE + 1),
    localparam int DW     = PW + 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NPROBE*PW-1:0] probe_i,
    input  logic                 cfg_we,
    input  logic [AW-1:0]        cfg_addr,
    input  logic [DW-1:0]        cfg_wdata,
    output logic                 trig_o,
    output logic                 qual_o
);
    logic [NPROBE-1:0][2:0]    t_op;
    logic [NPROBE-1:0][PW-1:0] t_val;
    logic [NPROBE-1:0][2:0]    c_op;
    logic [NPROBE-1:0][PW-1:0] c_val;
    logic                      t_and;
    logic                      c_and;

    logic [NPROBE*PW-1:0]      prev_q;
    logic [NPROBE-1:0]         t_hit, t_en, c_hit, c_en;
    logic                      t_match, c_match;
    logic                      hist_ok;

    hist_state_e st_q, st_d;

    trg_cfg_regs #(
        .NPROBE (NPROBE),
        .PW     (PW),
        .AW     (AW),
        .DW     (DW)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we),
        .addr_i  (cfg_addr),
        .wdata_i (cfg_wdata),
        .t_op_o  (t_op),
        .t_val_o (t_val),
        .c_op_o  (c_op),
        .c_val_o (c_val),
        .t_and_o (t_and),
        .c_and_o (c_and)
    );

    // History state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_WARM;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (st_q)
            ST_WARM: st_d = cfg_we ? ST_WARM : ST_LIVE;
            ST_LIVE: st_d = cfg_we ? ST_WARM : ST_LIVE;
            default: st_d = ST_WARM;
        endcase
    end

    assign hist_ok = (st_q == ST_LIVE);

    for (genvar p = 0; p < NPROBE; p++) begin : g_probe
        trg_probe_cmp #(.PW(PW)) u_tcmp (
            .op_i      (trg_op_e'(t_op[p])),
            .val_i     (t_val[p]),
            .cur_i     (probe_i[p*PW +: PW]),
            .prev_i    (prev_q[p*PW +: PW]),
            .hist_ok_i (hist_ok),
            .hit_o     (t_hit[p]),
            .en_o      (t_en[p])
        );

        trg_probe_cmp #(.PW(PW)) u_ccmp (
            .op_i      (trg_op_e'(c_op[p])),
            .val_i     (c_val[p]),
            .cur_i     (probe_i[p*PW +: PW]),
            .prev_i    (prev_q[p*PW +: PW]),
            .hist_ok_i (hist_ok),
            .hit_o     (c_hit[p]),
            .en_o      (c_en[p])
        );
    end

    trg_combine #(.NPROBE(NPROBE)) u_tcomb (
        .hit_i      (t_hit),
        .en_i       (t_en),
        .and_mode_i (t_and),
        .match_o    (t_match)
    );

    trg_combine #(.NPROBE(NPROBE)) u_ccomb (
        .hit_i      (c_hit),
        .en_i       (c_en),
        .and_mode_i (c_and),
        .match_o    (c_match)
    );

    // Output and history registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_o <= 1'b0;
            qual_o <= 1'b0;
            prev_q <= '0;
        end else begin
            trig_o <= t_match;
            qual_o <= c_match;
            prev_q <= probe_i;
        end
    end

endmodule

// File: rtl/trg_cond_eval_chk.sv
`timescale 1ns/1ps
module trg_cond_eval_chk #(
    parameter int NPROBE = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   trig_o,
    input logic                   qual_o,
    input logic [NPROBE-1:0]      t_hit,
    input logic [NPROBE-1:0]      t_en,
    input logic [NPROBE-1:0]      c_hit,
    input logic [NPROBE-1:0]      c_en,
    input logic [NPROBE-1:0][2:0] t_op,
    input logic                   t_and,
    input logic                   hist_ok
);
    // R10: an empty trigger set never raises the flag
    a_r10_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(t_en == '0) |-> !trig_o);

    // R9: a trigger flag needs at least one enabled match in the sample
    a_r9_flag_has_hit: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> $past(|(t_hit & t_en)));

    // R8: in AND mode every enabled comparator matched
    a_r8_and_all_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_o && $past(t_and)) |-> $past(&(t_hit | ~t_en)));

    // R11: qualify flag follows capture comparators
    a_r11_qual_has_hit: assert property (@(posedge clk) disable iff (!rst_n)
        qual_o |-> $past(|(c_hit & c_en)));

    // R7: no edge match while history is not yet valid
    for (genvar p = 0; p < NPROBE; p++) begin : g_edge
        a_r7_no_edge_warm: assert property (@(posedge clk) disable iff (!rst_n)
            (!hist_ok && t_op[p] >= 3'd5) |-> !t_hit[p]);
    end

endmodule

bind trg_cond_eval trg_cond_eval_chk #(.NPROBE(NPROBE)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig_o  (trig_o),
    .qual_o  (qual_o),
    .t_hit   (t_hit),
    .t_en    (t_en),
    .c_hit   (c_hit),
    .c_en    (c_en),
    .t_op    (t_op),
    .t_and   (t_and),
    .hist_ok (hist_ok)
);

// File: tb/test_trg_cond_eval.sv
`timescale 1ns/1ps
module test_trg_cond_eval;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] probe_i = '0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [10:0] cfg_wdata = '0;
    logic        trig_o, qual_o;

    int n_chk = 0;
    int n_err = 0;
    logic t_pre, t_got, q_got;

    always #4 clk = ~clk;

    trg_cond_eval i_trg_cond_eval (
        .clk       (clk),
        .rst_n     (rst_n),
        .probe_i   (probe_i),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .trig_o    (trig_o),
        .qual_o    (qual_o)
    );

    // Table layout: [31:28] req, [27:25] op, [24:17] value, [16:9] prev, [8:1] cur, [0] expected
    localparam logic [31:0] VEC [16] = '{
        {4'd2, 3'd1, 8'd9,   8'h00, 8'h09, 1'b1},  // R2 equal
        {4'd2, 3'd1, 8'd9,   8'h00, 8'h08, 1'b0},  // R2
        {4'd2, 3'd2, 8'd9,   8'h00, 8'h08, 1'b1},  // R2 not equal
        {4'd2, 3'd2, 8'd9,   8'h00, 8'h09, 1'b0},  // R2
        {4'd3, 3'd3, 8'd2,   8'h00, 8'h03, 1'b1},  // R3 greater
        {4'd3, 3'd3, 8'd2,   8'h00, 8'h02, 1'b0},  // R3
        {4'd3, 3'd3, 8'd2,   8'h00, 8'h80, 1'b1},  // R3 unsigned
        {4'd3, 3'd4, 8'd5,   8'h00, 8'h04, 1'b1},  // R3 less
        {4'd3, 3'd4, 8'd5,   8'h00, 8'h05, 1'b0},  // R3
        {4'd4, 3'd5, 8'd3,   8'h00, 8'h08, 1'b1},  // R4 rising
        {4'd4, 3'd5, 8'd3,   8'h08, 8'h08, 1'b0},  // R4
        {4'd5, 3'd6, 8'd3,   8'h08, 8'h00, 1'b1},  // R5 falling
        {4'd5, 3'd6, 8'd3,   8'h00, 8'h08, 1'b0},  // R5
        {4'd6, 3'd7, 8'd3,   8'h00, 8'h08, 1'b1},  // R6 either edge
        {4'd6, 3'd7, 8'd3,   8'h08, 8'h00, 1'b1},  // R6
        {4'd6, 3'd7, 8'd3,   8'hF7, 8'hF7, 1'b0}   // R6 steady bit
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [10:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = 4'(a);
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic samp(input logic [31:0] p);
        probe_i = p;
        t_pre = trig_o;
        @(posedge clk);
        #1;
        t_got = trig_o;
        q_got = qual_o;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cfg_we = 1'b0;
        probe_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #800000;
        n_err++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        do_reset();
        chk("R1 trig after reset", trig_o, 0);
        chk("R1 qual after reset", qual_o, 0);
        samp(32'hFFFF_FFFF);
        chk("R10 empty AND trig", t_got, 0);
        chk("R10 empty AND qual", q_got, 0);
        wr(8, 11'h000);
        samp(32'hFFFF_FFFF);
        chk("R10 empty OR trig", t_got, 0);

        // Table walk on probe 0
        do_reset();
        for (int i = 0; i < 16; i++) begin
            wr(0, {VEC[i][27:25], VEC[i][24:17]});
            samp({24'h0, VEC[i][16:9]});
            samp({24'h0, VEC[i][8:1]});
            chk($sformatf("R%0d table row %0d", VEC[i][31:28], i), t_got, VEC[i][0]);
        end

        // R7: first sample after reset / after a write
        do_reset();
        wr(0, {3'd5, 8'd0});
        samp(32'h1);
        chk("R7 no edge after write", t_got, 0);
        samp(32'h0);
        samp(32'h1);
        chk("R7 edge when history valid", t_got, 1);
        samp(32'h0);
        wr(8, 11'h003);
        samp(32'h1);
        chk("R7 mode write reprimes", t_got, 0);

        // R8: AND mode, probes 2 and 3 disabled
        do_reset();
        wr(0, {3'd1, 8'd5});
        wr(1, {3'd3, 8'd10});
        wr(8, 11'h003);
        samp(32'h0000_0B05);
        chk("R8 all match", t_got, 1);
        samp(32'h0000_0A05);
        chk("R8 one miss", t_got, 0);
        samp(32'h0000_0B04);
        chk("R8 other miss", t_got, 0);
        samp(32'hFFFF_0B05);
        chk("R8 disabled ignored", t_got, 1);

        // R9: OR mode
        wr(8, 11'h002);
        samp(32'h0000_0A05);
        chk("R9 first only", t_got, 1);
        samp(32'h0000_0B00);
        chk("R9 second only", t_got, 1);
        samp(32'h0000_0A04);
        chk("R12 old flag before edge", t_pre, 1);
        chk("R9 none", t_got, 0);

        // R12: write effect latency
        probe_i = 32'h0000_0006;
        wr(0, {3'd1, 8'd6});
        chk("R12 old config at write edge", trig_o, 0);
        samp(32'h0000_0006);
        chk("R12 new config next edge", t_got, 1);

        // R13: unused addresses change nothing
        wr(0, {3'd1, 8'd5});
        wr(15, {3'd1, 8'd7});
        wr(9, 11'h000);
        samp(32'h0000_0005);
        chk("R13 unused addr keeps cfg", t_got, 1);
        samp(32'h0000_0007);
        chk("R13 unused addr no new cfg", t_got, 0);

        // R11: capture set beside trigger set
        do_reset();
        wr(4, {3'd1, 8'd1});
        wr(5, {3'd1, 8'd0});
        wr(2, {3'd5, 8'd0});
        samp(32'h0000_0001);
        chk("R11 qual alone", q_got, 1);
        chk("R11 trig quiet", t_got, 0);
        samp(32'h0000_0101);
        chk("R11 qual miss", q_got, 0);
        samp(32'h0001_0001);
        chk("R11 both trig", t_got, 1);
        chk("R11 both qual", q_got, 1);
        samp(32'h0001_0001);
        chk("R11 trig ends", t_got, 0);
        chk("R11 qual holds", q_got, 1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule